// File: doc/BRIEF.md
# Pipelined Tower-Field AES Byte Substitution

This block computes the forward AES byte substitution arithmetically, with no stored 256-entry table. An incoming byte is carried by a linear change of basis into a tower field, GF(2^8) built as a degree-two extension of GF(2^4). There the multiplicative inverse is found using only 4-bit multiplications and squarings. A second linear map returns the result to the AES polynomial basis, and the same map also applies the linear part of the affine transform. The constant 0x63 is added last.

The datapath is cut into seven register stages. One byte is accepted on every clock, and each result leaves a fixed number of cycles later. The stream interface has only valid flags, so there is no back-pressure: `in_byte` is taken on every rising edge where `in_valid` is high, and the downstream side must accept `out_byte` whenever `out_valid` is high. The change-of-basis matrices and the tower-field constant are computed at elaboration time from the field polynomials.

Top module: `sbx_pipe`

## Requirements
- R1: For every input value 0x00..0xFF, `out_byte` equals the AES S-box value. That value is the inverse of the input in GF(2^8) modulo x^8+x^4+x^3+x+1, with zero taken as its own inverse, followed by the affine transform b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R2: Input 0x00 yields 0x63.
- R3: A byte sampled at rising edge n is present on `out_byte` with `out_valid` high from rising edge n+6 until edge n+7. That is a seven-register latency.
- R4: Bytes offered on consecutive cycles are all accepted and come out on consecutive cycles, in the same order, without stalls.
- R5: `out_valid` repeats the `in_valid` pattern delayed by the latency of R3. Cycles with `in_valid` low produce cycles with `out_valid` low.
- R6: A synchronous active-high `rst` clears every stage's valid flag. `out_valid` is low on the cycle after reset, and no byte presented before or during reset ever emerges.
- R7: Inside the tower field, the product of a nonzero operand and its computed inverse is one, and a zero operand gives a zero inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Output byte is present this cycle |
| out_byte | output | 8 | Substituted byte |

## Verification
A short list of known substitution pairs runs back to back. It includes 0x00, 0x01, 0xFF and single-bit inputs, which separate an error in the basis matrices from an error in the constant. All 256 inputs then stream without gaps and are compared against an inverse-by-search model in GF(2^8); this shows every bit of both matrices and of the subfield inverse in use. A sparse valid pattern and an isolated byte separate correct latency and valid tracking from a design that merely has the right data. A reset in mid-stream shows that in-flight bytes are discarded.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int N_STAGE = 7;
  localparam logic [BYTE_W-1:0] AFF_CONST = 8'h63;

  // GF(2^4) multiply, modulus x^4 + x + 1
  function automatic logic [NIB_W-1:0] g16_mul(input logic [NIB_W-1:0] a,
                                               input logic [NIB_W-1:0] b);
    logic [NIB_W-1:0] r;
    logic [NIB_W-1:0] t;
    r = '0;
    t = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) r = r ^ t;
      t = t[3] ? ({t[2:0], 1'b0} ^ 4'b0011) : {t[2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [NIB_W-1:0] g16_sq(input logic [NIB_W-1:0] a);
    return g16_mul(a, a);
  endfunction

  // smallest nu with y^2 + y + nu irreducible over GF(2^4)
  function automatic logic [NIB_W-1:0] pick_nu();
    logic [NIB_W-1:0] found;
    logic ok;
    found = '0;
    for (int l = 1; l < 16; l++) begin
      ok = 1'b1;
      for (int t = 0; t < 16; t++)
        if ((g16_mul(4'(t), 4'(t)) ^ 4'(t)) == 4'(l)) ok = 1'b0;
      if (ok && found == '0) found = 4'(l);
    end
    return found;
  endfunction

  localparam logic [NIB_W-1:0] NU = pick_nu();

  // tower-field multiply: element = hi*y + lo, y^2 = y + NU
  function automatic logic [BYTE_W-1:0] t_mul(input logic [BYTE_W-1:0] a,
                                              input logic [BYTE_W-1:0] b);
    logic [NIB_W-1:0] hh;
    logic [NIB_W-1:0] hi;
    logic [NIB_W-1:0] lo;
    hh = g16_mul(a[7:4], b[7:4]);
    hi = hh ^ g16_mul(a[7:4], b[3:0]) ^ g16_mul(a[3:0], b[7:4]);
    lo = g16_mul(hh, NU) ^ g16_mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  // a tower-field root of x^8 + x^4 + x^3 + x + 1
  function automatic logic [BYTE_W-1:0] find_root();
    logic [BYTE_W-1:0] root;
    logic [BYTE_W-1:0] x2, x3, x4, x8, v;
    root = '0;
    for (int c = 1; c < 256; c++) begin
      x2 = t_mul(8'(c), 8'(c));
      x3 = t_mul(x2, 8'(c));
      x4 = t_mul(x2, x2);
      x8 = t_mul(x4, x4);
      v  = x8 ^ x4 ^ x3 ^ 8'(c) ^ 8'h01;
      if (v == '0 && root == '0) root = 8'(c);
    end
    return root;
  endfunction

  // column i of a matrix sits in bits [8i +: 8]
  function automatic logic [BYTE_W-1:0] mat_apply(input logic [63:0] m,
                                                  input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (a[i]) r = r ^ m[8*i +: 8];
    return r;
  endfunction

  function automatic logic [63:0] entry_matrix();
    logic [63:0] m;
    logic [BYTE_W-1:0] beta;
    logic [BYTE_W-1:0] pw;
    beta = find_root();
    pw   = 8'h01;
    m    = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      m[8*i +: 8] = pw;
      pw = t_mul(pw, beta);
    end
    return m;
  endfunction

  function automatic logic [BYTE_W-1:0] aff_lin(input logic [BYTE_W-1:0] b);
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]};
  endfunction

  // inverse basis change with the affine linear part folded in
  function automatic logic [63:0] exit_matrix();
    logic [63:0] fwd;
    logic [63:0] m;
    fwd = entry_matrix();
    m   = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int v = 0; v < 256; v++)
        if (mat_apply(fwd, 8'(v)) == 8'(1 << j)) m[8*j +: 8] = aff_lin(8'(v));
    return m;
  endfunction

  localparam logic [63:0] ENTRY_MAT = entry_matrix();
  localparam logic [63:0] EXIT_MAT  = exit_matrix();

endpackage

// File: rtl/sbx_lin8.sv
module sbx_lin8 #(
  parameter int          W   = 8,
  parameter logic [63:0] MAT = 64'h0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  // output bit o is the parity of a masked by row o of MAT
  for (genvar o = 0; o < W; o++) begin : g_row
    logic [W-1:0] row;
    for (genvar i = 0; i < W; i++) begin : g_col
      assign row[i] = MAT[W*i + o];
    end
    assign y[o] = ^(a & row);
  end
endmodule

// File: rtl/sbx_tower_inv.sv
module sbx_tower_inv
  import sbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              v_in,
  input  logic [BYTE_W-1:0] op_in,
  output logic              v_out,
  output logic [BYTE_W-1:0] inv_out
);
  localparam int DEPTH = 4;

  logic [DEPTH-1:0] vld;
  logic [BYTE_W-1:0] op_q [DEPTH];

  // stage A: norm  delta = hi^2*NU + hi*lo + lo^2
  logic [NIB_W-1:0] dl_q;
  // stage B: delta^6 and delta^8
  logic [NIB_W-1:0] p6_q, p8_q;
  // stage C: delta^-1 = delta^14
  logic [NIB_W-1:0] di_q;
  // stage D: result
  logic [BYTE_W-1:0] res_q;

  logic [NIB_W-1:0] sq2, sq4, sq8;
  always_comb begin
    sq2 = g16_sq(dl_q);
    sq4 = g16_sq(sq2);
    sq8 = g16_sq(sq4);
  end

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[DEPTH-2:0], v_in};
  end

  always_ff @(posedge clk) begin
    op_q[0] <= op_in;
    dl_q    <= g16_mul(g16_sq(op_in[7:4]), NU) ^ g16_mul(op_in[7:4], op_in[3:0])
               ^ g16_sq(op_in[3:0]);
    p6_q    <= g16_mul(sq2, sq4);
    p8_q    <= sq8;
    di_q    <= g16_mul(p6_q, p8_q);
    res_q   <= {g16_mul(op_q[2][7:4], di_q),
                g16_mul(op_q[2][7:4] ^ op_q[2][3:0], di_q)};
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_carry
    always_ff @(posedge clk) op_q[k] <= op_q[k-1];
  end

  assign v_out   = vld[DEPTH-1];
  assign inv_out = res_q;

  AST_INV_ONE: assert property (@(posedge clk) disable iff (rst)
    (vld[DEPTH-1] && op_q[DEPTH-1] != '0) |-> t_mul(res_q, op_q[DEPTH-1]) == 8'h01); // R7
  AST_INV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (vld[DEPTH-1] && op_q[DEPTH-1] == '0) |-> res_q == '0); // R7
endmodule

// File: rtl/sbx_pipe.sv
module sbx_pipe
  import sbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte
);
  logic [BYTE_W-1:0] ent_c, ext_c, inv_c;
  logic [BYTE_W-1:0] s1_q, s6_q, s7_q;
  logic v1_q, v5_c, v6_q, v7_q;

  sbx_lin8 #(.W(BYTE_W), .MAT(ENTRY_MAT)) u_entry (.a(in_byte), .y(ent_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v6_q <= 1'b0;
      v7_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v6_q <= v5_c;
      v7_q <= v6_q;
    end
  end

  always_ff @(posedge clk) s1_q <= ent_c;

  sbx_tower_inv u_inv (
    .clk(clk), .rst(rst), .v_in(v1_q), .op_in(s1_q),
    .v_out(v5_c), .inv_out(inv_c)
  );

  sbx_lin8 #(.W(BYTE_W), .MAT(EXIT_MAT)) u_exit (.a(inv_c), .y(ext_c));

  always_ff @(posedge clk) begin
    s6_q <= ext_c;
    s7_q <= s6_q ^ AFF_CONST;
  end

  assign out_valid = v7_q;
  assign out_byte  = s7_q;

  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R6
  AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (v1_q && s1_q == '0) |-> $past(in_byte) == '0); // R1
  AST_OUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(v6_q)); // R5
endmodule

// File: tb/sim_sbx_pipe.sv
module sim_sbx_pipe;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_valid;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;

  logic       hv [7];
  logic [7:0] hx [7];
  string      ht [7];

  always #2 clk = ~clk;

  sbx_pipe u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
               .out_valid(out_valid), .out_byte(out_byte));

  // known pairs: {input, expected}
  localparam logic [15:0] VEC [12] = '{
    16'h0063, 16'h017C, 16'h0277, 16'h037B, 16'h10CA, 16'h1182,
    16'h1FC0, 16'h53ED, 16'h0F76, 16'h80CD, 16'hAAAC, 16'hFF16 };

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, t;
    r = 0; t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= t;
      t = t[7] ? ({t[6:0], 1'b0} ^ 8'h1B) : {t[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_sub(input logic [7:0] a);
    logic [7:0] iv, b;
    iv = 0;
    for (int v = 1; v < 256; v++)
      if (gmul(a, 8'(v)) == 8'h01) iv = 8'(v);
    b = iv;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  task automatic check(input logic ok, input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clr_hist();
    for (int k = 0; k < 7; k++) begin hv[k] = 0; hx[k] = 0; ht[k] = "R6"; end
  endtask

  // one cycle: check what entered seven edges ago, then drive
  task automatic step(input logic v, input logic [7:0] b, input logic [7:0] e,
                      input string tag);
    @(negedge clk);
    check(out_valid == hv[6], ht[6], {7'b0, out_valid}, {7'b0, hv[6]});
    if (hv[6] && out_valid) check(out_byte == hx[6], ht[6], out_byte, hx[6]);
    for (int k = 6; k > 0; k--) begin hv[k] = hv[k-1]; hx[k] = hx[k-1]; ht[k] = ht[k-1]; end
    hv[0] = v; hx[0] = e; ht[0] = tag;
    in_valid = v; in_byte = b;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 8; k++) step(1'b0, 8'h00, 8'h00, tag);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_hist();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6: reset state
    check(out_valid == 1'b0, "R6", {7'b0, out_valid}, 8'h00);

    // R1 R2: known pairs back to back
    for (int i = 0; i < 12; i++)
      step(1'b1, VEC[i][15:8], VEC[i][7:0], (VEC[i][15:8] == 8'h00) ? "R2" : "R1");
    drain("R1");

    // R3: isolated byte, valid exactly once seven edges later
    step(1'b1, 8'h53, 8'hED, "R3");
    drain("R3");

    // R1 R4: full sweep without gaps
    for (int c = 0; c < 256; c++) step(1'b1, 8'(c), ref_sub(8'(c)), "R4");
    drain("R4");

    // R5: bubbles preserved
    for (int i = 0; i < 30; i++)
      step((i % 3) != 0, 8'(i * 37), ref_sub(8'(i * 37)), "R5");
    drain("R5");

    // R6: reset in mid-stream discards in-flight bytes
    for (int i = 0; i < 4; i++) step(1'b1, 8'(i + 200), ref_sub(8'(i + 200)), "R6");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_byte = 8'hA5;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    check(out_valid == 1'b0, "R6", {7'b0, out_valid}, 8'h00);
    clr_hist();
    drain("R6");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule